// File: doc/BRIEF.md
# Kernel Completion Tracker

This block keeps one record per in-flight kernel in a small table addressed by kernel ID. Each record counts cache invalidations still in flight, cache writebacks still in flight, workgroups finished so far and workgroups expected in total. A scheduler allocates a record when a kernel is handed over. Memory-side logic then reports invalidate and writeback traffic as single-step increments or decrements. Compute units report each finished workgroup.

The block tells the dispatcher when to look again through a level wake-up request. It tells writeback logic when a kernel's writebacks have drained. It answers a combinational query on whether the next workgroup to finish is the final one.

When the last workgroup finishes, the block pulses a finish notification carrying the kernel's packet reference and queue number. If the kernel was given a nonzero completion-signal address, the block then reads that location over a request/response handshake, subtracts one and writes the result back. Only one such read-modify-write is in flight at a time. A record is released when its finish pulse goes out (no signal address) or when its signal write is acknowledged.

Top module: `kernel_done_tracker`

## Requirements
- R1: An allocate request fills the record of a free ID with zeroed counters and the given total, packet reference, queue number and signal address. An allocate to an ID already in use, or with a total of zero, pulses `err_o` one cycle later and changes nothing.
- R2: A counter update code is 2'b01 for +1 and 2'b11 for -1. Codes 2'b00 and 2'b10 pulse `err_o` one cycle later and leave the counter unchanged, and no writeback response is given.
- R3: An invalidate update of -1 that takes the count to zero pulses `inv_drained_o` one cycle later, with the kernel ID on `inv_drained_kid_o`.
- R4: A legal writeback update gives `wb_resp_valid_o` one cycle later, with `wb_done_o` high exactly when the count after the update is zero.
- R5: `wake_req_o` goes high one cycle after an invalidate drain or an accepted workgroup completion. It stays high until a cycle with `wake_ack_i` and no new trigger.
- R6: `lastq_is_last_o` is high, in the same cycle, exactly when the queried ID is in use and its completed count plus one equals its total.
- R7: Each accepted workgroup completion adds one to the completed count. The completion that reaches the total pulses `fin_valid_o` one cycle later, with the stored packet reference and queue number.
- R8: A finished kernel with a nonzero signal address raises `sig_rd_req_o` with that address, held until a read response. Then `sig_wr_req_o` is raised with the response value minus one, held until `sig_wr_ack_i`. A kernel with signal address zero issues no read and is released at its finish pulse.
- R9: Signal read-modify-writes are serialised. No read request is raised while a write is waiting for its acknowledge, and a second finished kernel waits until the first write is acknowledged.
- R10: An update or workgroup completion naming an ID that is not in use, or that has already reached its total, pulses `err_o` and changes no state, and raises no wake-up or finish pulse.
- R11: An increment at the counter's maximum value, or a decrement at zero, pulses `err_o` and leaves the counter unchanged.
- R12: After reset every record is free, and all request, pulse and error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Allocate a record |
| alloc_kid_i | input | KID_W | Kernel ID to allocate |
| alloc_wg_total_i | input | WG_W | Workgroups in the kernel |
| alloc_pkt_ref_i | input | PKT_W | Packet reference returned at finish |
| alloc_queue_id_i | input | QID_W | Queue number returned at finish |
| alloc_sig_handle_i | input | ADDR_W | Completion-signal address, zero for none |
| inv_valid_i | input | 1 | Invalidate counter update |
| inv_kid_i | input | KID_W | Kernel ID of the invalidate update |
| inv_delta_i | input | 2 | Invalidate update code |
| inv_drained_o | output | 1 | Invalidate count reached zero |
| inv_drained_kid_o | output | KID_W | Kernel whose invalidates drained |
| wb_valid_i | input | 1 | Writeback counter update |
| wb_kid_i | input | KID_W | Kernel ID of the writeback update |
| wb_delta_i | input | 2 | Writeback update code |
| wb_resp_valid_o | output | 1 | Writeback update response |
| wb_done_o | output | 1 | Writeback count is zero after the update |
| wg_valid_i | input | 1 | A workgroup finished |
| wg_kid_i | input | KID_W | Kernel of the finished workgroup |
| lastq_kid_i | input | KID_W | Kernel ID to query |
| lastq_is_last_o | output | 1 | Next finishing workgroup is the last |
| wake_req_o | output | 1 | Dispatcher wake-up request |
| wake_ack_i | input | 1 | Wake-up taken |
| fin_valid_o | output | 1 | Kernel finish pulse |
| fin_pkt_ref_o | output | PKT_W | Packet reference of the finished kernel |
| fin_queue_id_o | output | QID_W | Queue number of the finished kernel |
| sig_rd_req_o | output | 1 | Signal read request |
| sig_rd_addr_o | output | ADDR_W | Signal read address |
| sig_rd_rsp_valid_i | input | 1 | Signal read response |
| sig_rd_rsp_data_i | input | VAL_W | Signal value read |
| sig_wr_req_o | output | 1 | Signal write request |
| sig_wr_addr_o | output | ADDR_W | Signal write address |
| sig_wr_data_o | output | VAL_W | Decremented signal value |
| sig_wr_ack_i | input | 1 | Signal write accepted |
| err_o | output | 1 | Illegal request seen last cycle |

## Verification
The bench builds the tracker with four records and 3-bit update counters. This lets it drive a counter into both its ceiling and its floor within a handful of updates, and exercise illegal codes on the same record. Four-bit workgroup totals keep kernel completion a few events away. Four records leave room for a kernel with no signal address, one rejected allocation, and two kernels with signal addresses that contend for the single read-modify-write engine.

// File: rtl/kdt_pkg.sv
package kdt_pkg;

    localparam logic [1:0] DELTA_INC = 2'b01;
    localparam logic [1:0] DELTA_DEC = 2'b11;

    typedef struct packed {
        logic inc;
        logic dec;
        logic bad;
    } delta_t;

    typedef enum logic [1:0] {
        SIG_IDLE = 2'd0,
        SIG_RD   = 2'd1,
        SIG_WR   = 2'd2
    } sig_state_e;

endpackage

// File: rtl/kdt_delta_decode.sv
module kdt_delta_decode
    import kdt_pkg::*;
(
    input  logic [1:0] code_i,
    output delta_t     delta_o
);
    always_comb begin
        delta_o.inc = (code_i == DELTA_INC);
        delta_o.dec = (code_i == DELTA_DEC);
        delta_o.bad = !(delta_o.inc || delta_o.dec);
    end
endmodule

// File: rtl/kdt_cnt_step.sv
module kdt_cnt_step
    import kdt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_i,
    input  delta_t       delta_i,
    output logic [W-1:0] nxt_o,
    output logic         err_o,
    output logic         zero_o
);
    always_comb begin
        nxt_o = cur_i;
        err_o = delta_i.bad;
        if (delta_i.inc) begin
            if (cur_i == {W{1'b1}}) err_o = 1'b1;
            else                    nxt_o = cur_i + W'(1);
        end
        if (delta_i.dec) begin
            if (cur_i == '0) err_o = 1'b1;
            else             nxt_o = cur_i - W'(1);
        end
        zero_o = (nxt_o == '0);
    end
endmodule

// File: rtl/kdt_wake.sv
module kdt_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic ack_i,
    output logic req_o
);
    logic req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (ack_i)  req_d = 1'b0;
        if (trig_i) req_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req_o = req_q;
endmodule

// File: rtl/kdt_sig_engine.sv
module kdt_sig_engine
    import kdt_pkg::*;
#(
    parameter int NK     = 8,
    parameter int KID_W  = 3,
    parameter int ADDR_W = 32,
    parameter int VAL_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NK-1:0]              pend_i,
    input  logic [NK-1:0][ADDR_W-1:0]  handle_i,
    output logic                       rd_req_o,
    output logic [ADDR_W-1:0]          rd_addr_o,
    input  logic                       rd_rsp_valid_i,
    input  logic [VAL_W-1:0]           rd_rsp_data_i,
    output logic                       wr_req_o,
    output logic [ADDR_W-1:0]          wr_addr_o,
    output logic [VAL_W-1:0]           wr_data_o,
    input  logic                       wr_ack_i,
    output logic                       done_valid_o,
    output logic [KID_W-1:0]           done_kid_o
);
    typedef struct packed {
        sig_state_e        state;
        logic [KID_W-1:0]  kid;
        logic [ADDR_W-1:0] addr;
        logic [VAL_W-1:0]  data;
    } eng_t;

    eng_t eng_d, eng_q;
    logic found;

    always_comb begin
        eng_d = eng_q;
        found = 1'b0;
        case (eng_q.state)
            SIG_IDLE: begin
                for (int i = 0; i < NK; i++) begin
                    if (pend_i[i] && !found) begin
                        found     = 1'b1;
                        eng_d.kid = KID_W'(i);
                    end
                end
                if (found) begin
                    eng_d.addr  = handle_i[eng_d.kid];
                    eng_d.state = SIG_RD;
                end
            end
            SIG_RD: begin
                if (rd_rsp_valid_i) begin
                    eng_d.data  = rd_rsp_data_i - VAL_W'(1);
                    eng_d.state = SIG_WR;
                end
            end
            SIG_WR: begin
                if (wr_ack_i) eng_d.state = SIG_IDLE;
            end
            default: eng_d.state = SIG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{state: SIG_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    assign rd_req_o     = (eng_q.state == SIG_RD);
    assign wr_req_o     = (eng_q.state == SIG_WR);
    assign rd_addr_o    = eng_q.addr;
    assign wr_addr_o    = eng_q.addr;
    assign wr_data_o    = eng_q.data;
    assign done_valid_o = (eng_q.state == SIG_WR) && wr_ack_i;
    assign done_kid_o   = eng_q.kid;
endmodule

// File: rtl/kernel_done_tracker.sv
module kernel_done_tracker
    import kdt_pkg::*;
#(
    parameter int NUM_KERNELS = 8,
    parameter int CNT_W       = 8,
    parameter int WG_W        = 12,
    parameter int PKT_W       = 32,
    parameter int QID_W       = 4,
    parameter int ADDR_W      = 32,
    parameter int VAL_W       = 32,
    localparam int KID_W      = (NUM_KERNELS > 1) ? $clog2(NUM_KERNELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    input  logic [KID_W-1:0]  alloc_kid_i,
    input  logic [WG_W-1:0]   alloc_wg_total_i,
    input  logic [PKT_W-1:0]  alloc_pkt_ref_i,
    input  logic [QID_W-1:0]  alloc_queue_id_i,
    input  logic [ADDR_W-1:0] alloc_sig_handle_i,
    input  logic              inv_valid_i,
    input  logic [KID_W-1:0]  inv_kid_i,
    input  logic [1:0]        inv_delta_i,
    output logic              inv_drained_o,
    output logic [KID_W-1:0]  inv_drained_kid_o,
    input  logic              wb_valid_i,
    input  logic [KID_W-1:0]  wb_kid_i,
    input  logic [1:0]        wb_delta_i,
    output logic              wb_resp_valid_o,
    output logic              wb_done_o,
    input  logic              wg_valid_i,
    input  logic [KID_W-1:0]  wg_kid_i,
    input  logic [KID_W-1:0]  lastq_kid_i,
    output logic              lastq_is_last_o,
    output logic              wake_req_o,
    input  logic              wake_ack_i,
    output logic              fin_valid_o,
    output logic [PKT_W-1:0]  fin_pkt_ref_o,
    output logic [QID_W-1:0]  fin_queue_id_o,
    output logic              sig_rd_req_o,
    output logic [ADDR_W-1:0] sig_rd_addr_o,
    input  logic              sig_rd_rsp_valid_i,
    input  logic [VAL_W-1:0]  sig_rd_rsp_data_i,
    output logic              sig_wr_req_o,
    output logic [ADDR_W-1:0] sig_wr_addr_o,
    output logic [VAL_W-1:0]  sig_wr_data_o,
    input  logic              sig_wr_ack_i,
    output logic              err_o
);
    localparam int NLANE    = 2;
    localparam int LANE_INV = 0;
    localparam int LANE_WB  = 1;

    typedef struct packed {
        logic              valid;
        logic [CNT_W-1:0]  inv_cnt;
        logic [CNT_W-1:0]  wb_cnt;
        logic [WG_W-1:0]   wg_done;
        logic [WG_W-1:0]   wg_total;
        logic [PKT_W-1:0]  pkt_ref;
        logic [QID_W-1:0]  queue_id;
        logic [ADDR_W-1:0] handle;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_KERNELS-1:0] tbl;
        logic                     inv_drained;
        logic [KID_W-1:0]         drained_kid;
        logic                     wb_resp;
        logic                     wb_done;
        logic                     fin_valid;
        logic [PKT_W-1:0]         fin_pkt;
        logic [QID_W-1:0]         fin_qid;
        logic                     err;
    } state_t;

    state_t st_d, st_q;
    logic   wake_trig;

    // Counter update lanes: lane 0 invalidates, lane 1 writebacks
    logic [NLANE-1:0][1:0]       lane_code;
    logic [NLANE-1:0][CNT_W-1:0] lane_cur;
    logic [NLANE-1:0][CNT_W-1:0] lane_nxt;
    logic [NLANE-1:0]            lane_err;
    logic [NLANE-1:0]            lane_zero;
    delta_t [NLANE-1:0]          lane_delta;

    assign lane_code[LANE_INV] = inv_delta_i;
    assign lane_code[LANE_WB]  = wb_delta_i;
    assign lane_cur[LANE_INV]  = st_q.tbl[inv_kid_i].inv_cnt;
    assign lane_cur[LANE_WB]   = st_q.tbl[wb_kid_i].wb_cnt;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        kdt_delta_decode u_dec (
            .code_i  (lane_code[g]),
            .delta_o (lane_delta[g])
        );
        kdt_cnt_step #(.W(CNT_W)) u_step (
            .cur_i   (lane_cur[g]),
            .delta_i (lane_delta[g]),
            .nxt_o   (lane_nxt[g]),
            .err_o   (lane_err[g]),
            .zero_o  (lane_zero[g])
        );
    end

    // Completion-signal engine inputs
    logic [NUM_KERNELS-1:0]             sig_pend;
    logic [NUM_KERNELS-1:0][ADDR_W-1:0] sig_handle;
    logic                               sig_done;
    logic [KID_W-1:0]                   sig_done_kid;

    for (genvar k = 0; k < NUM_KERNELS; k++) begin : g_pend
        assign sig_pend[k]   = st_q.tbl[k].valid &&
                               (st_q.tbl[k].wg_done == st_q.tbl[k].wg_total);
        assign sig_handle[k] = st_q.tbl[k].handle;
    end

    kdt_sig_engine #(
        .NK     (NUM_KERNELS),
        .KID_W  (KID_W),
        .ADDR_W (ADDR_W),
        .VAL_W  (VAL_W)
    ) u_sig (
        .clk            (clk),
        .rst_n          (rst_n),
        .pend_i         (sig_pend),
        .handle_i       (sig_handle),
        .rd_req_o       (sig_rd_req_o),
        .rd_addr_o      (sig_rd_addr_o),
        .rd_rsp_valid_i (sig_rd_rsp_valid_i),
        .rd_rsp_data_i  (sig_rd_rsp_data_i),
        .wr_req_o       (sig_wr_req_o),
        .wr_addr_o      (sig_wr_addr_o),
        .wr_data_o      (sig_wr_data_o),
        .wr_ack_i       (sig_wr_ack_i),
        .done_valid_o   (sig_done),
        .done_kid_o     (sig_done_kid)
    );

    kdt_wake u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (wake_trig),
        .ack_i  (wake_ack_i),
        .req_o  (wake_req_o)
    );

    // Workgroup lookup
    entry_t          wg_ent;
    logic [WG_W-1:0] wg_next;
    assign wg_ent  = st_q.tbl[wg_kid_i];
    assign wg_next = wg_ent.wg_done + WG_W'(1);

    always_comb begin
        st_d             = st_q;
        st_d.inv_drained = 1'b0;
        st_d.wb_resp     = 1'b0;
        st_d.wb_done     = 1'b0;
        st_d.fin_valid   = 1'b0;
        st_d.err         = 1'b0;
        wake_trig        = 1'b0;

        if (alloc_valid_i) begin
            if (st_q.tbl[alloc_kid_i].valid || (alloc_wg_total_i == '0)) begin
                st_d.err = 1'b1;
            end else begin
                st_d.tbl[alloc_kid_i].valid    = 1'b1;
                st_d.tbl[alloc_kid_i].inv_cnt  = '0;
                st_d.tbl[alloc_kid_i].wb_cnt   = '0;
                st_d.tbl[alloc_kid_i].wg_done  = '0;
                st_d.tbl[alloc_kid_i].wg_total = alloc_wg_total_i;
                st_d.tbl[alloc_kid_i].pkt_ref  = alloc_pkt_ref_i;
                st_d.tbl[alloc_kid_i].queue_id = alloc_queue_id_i;
                st_d.tbl[alloc_kid_i].handle   = alloc_sig_handle_i;
            end
        end

        if (inv_valid_i) begin
            if (!st_q.tbl[inv_kid_i].valid || lane_err[LANE_INV]) begin
                st_d.err = 1'b1;
            end else begin
                st_d.tbl[inv_kid_i].inv_cnt = lane_nxt[LANE_INV];
                if (lane_delta[LANE_INV].dec && lane_zero[LANE_INV]) begin
                    st_d.inv_drained = 1'b1;
                    st_d.drained_kid = inv_kid_i;
                    wake_trig        = 1'b1;
                end
            end
        end

        if (wb_valid_i) begin
            if (!st_q.tbl[wb_kid_i].valid || lane_err[LANE_WB]) begin
                st_d.err = 1'b1;
            end else begin
                st_d.tbl[wb_kid_i].wb_cnt = lane_nxt[LANE_WB];
                st_d.wb_resp              = 1'b1;
                st_d.wb_done              = lane_zero[LANE_WB];
            end
        end

        if (wg_valid_i) begin
            if (!wg_ent.valid || (wg_ent.wg_done == wg_ent.wg_total)) begin
                st_d.err = 1'b1;
            end else begin
                st_d.tbl[wg_kid_i].wg_done = wg_next;
                wake_trig                  = 1'b1;
                if (wg_next == wg_ent.wg_total) begin
                    st_d.fin_valid = 1'b1;
                    st_d.fin_pkt   = wg_ent.pkt_ref;
                    st_d.fin_qid   = wg_ent.queue_id;
                    if (wg_ent.handle == '0) st_d.tbl[wg_kid_i].valid = 1'b0;
                end
            end
        end

        if (sig_done) st_d.tbl[sig_done_kid].valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign inv_drained_o     = st_q.inv_drained;
    assign inv_drained_kid_o = st_q.drained_kid;
    assign wb_resp_valid_o   = st_q.wb_resp;
    assign wb_done_o         = st_q.wb_done;
    assign fin_valid_o       = st_q.fin_valid;
    assign fin_pkt_ref_o     = st_q.fin_pkt;
    assign fin_queue_id_o    = st_q.fin_qid;
    assign err_o             = st_q.err;
    assign lastq_is_last_o   = st_q.tbl[lastq_kid_i].valid &&
        ((st_q.tbl[lastq_kid_i].wg_done + WG_W'(1)) == st_q.tbl[lastq_kid_i].wg_total);
endmodule

// File: rtl/kdt_checker.sv
module kdt_checker #(
    parameter int ADDR_W = 32,
    parameter int VAL_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sig_rd_req_o,
    input logic [ADDR_W-1:0] sig_rd_addr_o,
    input logic              sig_rd_rsp_valid_i,
    input logic              sig_wr_req_o,
    input logic [VAL_W-1:0]  sig_wr_data_o,
    input logic              sig_wr_ack_i,
    input logic              wake_req_o,
    input logic              wake_ack_i,
    input logic              inv_drained_o,
    input logic              wb_resp_valid_o,
    input logic              wb_valid_i
);
    assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sig_rd_req_o && sig_wr_req_o));

    assert_wr_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_wr_req_o) |-> $past(sig_rd_req_o && sig_rd_rsp_valid_i));

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_rd_req_o && !sig_rd_rsp_valid_i) |=> (sig_rd_req_o && $stable(sig_rd_addr_o)));

    assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_wr_req_o && !sig_wr_ack_i) |=> (sig_wr_req_o && $stable(sig_wr_data_o)));

    assert_wake_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_o && !wake_ack_i) |=> wake_req_o);

    assert_drain_wakes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_drained_o |-> wake_req_o);

    assert_wb_resp_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_resp_valid_o |-> $past(wb_valid_i));
endmodule

bind kernel_done_tracker kdt_checker #(.ADDR_W(ADDR_W), .VAL_W(VAL_W)) u_kdt_checker (
    .clk                (clk),
    .rst_n              (rst_n),
    .sig_rd_req_o       (sig_rd_req_o),
    .sig_rd_addr_o      (sig_rd_addr_o),
    .sig_rd_rsp_valid_i (sig_rd_rsp_valid_i),
    .sig_wr_req_o       (sig_wr_req_o),
    .sig_wr_data_o      (sig_wr_data_o),
    .sig_wr_ack_i       (sig_wr_ack_i),
    .wake_req_o         (wake_req_o),
    .wake_ack_i         (wake_ack_i),
    .inv_drained_o      (inv_drained_o),
    .wb_resp_valid_o    (wb_resp_valid_o),
    .wb_valid_i         (wb_valid_i)
);

// File: tb/kernel_done_tracker_bench.sv
module kernel_done_tracker_bench;
    localparam int NK = 4;
    localparam int KW = 2;
    localparam int CW = 3;
    localparam int WW = 4;
    localparam int PW = 16;
    localparam int QW = 4;
    localparam int AW = 16;
    localparam int VW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          alloc_valid = 0;
    logic [KW-1:0] alloc_kid = 0;
    logic [WW-1:0] alloc_total = 0;
    logic [PW-1:0] alloc_pkt = 0;
    logic [QW-1:0] alloc_qid = 0;
    logic [AW-1:0] alloc_handle = 0;
    logic          inv_valid = 0;
    logic [KW-1:0] inv_kid = 0;
    logic [1:0]    inv_delta = 0;
    logic          inv_drained;
    logic [KW-1:0] inv_drained_kid;
    logic          wb_valid = 0;
    logic [KW-1:0] wb_kid = 0;
    logic [1:0]    wb_delta = 0;
    logic          wb_resp, wb_done;
    logic          wg_valid = 0;
    logic [KW-1:0] wg_kid = 0;
    logic [KW-1:0] lastq_kid = 0;
    logic          lastq_is_last;
    logic          wake_req;
    logic          wake_ack = 0;
    logic          fin_valid;
    logic [PW-1:0] fin_pkt;
    logic [QW-1:0] fin_qid;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_rsp_valid = 0;
    logic [VW-1:0] rd_rsp_data = 0;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [VW-1:0] wr_data;
    logic          wr_ack = 0;
    logic          err;

    kernel_done_tracker #(
        .NUM_KERNELS(NK), .CNT_W(CW), .WG_W(WW), .PKT_W(PW),
        .QID_W(QW), .ADDR_W(AW), .VAL_W(VW)
    ) u_kernel_done_tracker (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid), .alloc_kid_i(alloc_kid),
        .alloc_wg_total_i(alloc_total), .alloc_pkt_ref_i(alloc_pkt),
        .alloc_queue_id_i(alloc_qid), .alloc_sig_handle_i(alloc_handle),
        .inv_valid_i(inv_valid), .inv_kid_i(inv_kid), .inv_delta_i(inv_delta),
        .inv_drained_o(inv_drained), .inv_drained_kid_o(inv_drained_kid),
        .wb_valid_i(wb_valid), .wb_kid_i(wb_kid), .wb_delta_i(wb_delta),
        .wb_resp_valid_o(wb_resp), .wb_done_o(wb_done),
        .wg_valid_i(wg_valid), .wg_kid_i(wg_kid),
        .lastq_kid_i(lastq_kid), .lastq_is_last_o(lastq_is_last),
        .wake_req_o(wake_req), .wake_ack_i(wake_ack),
        .fin_valid_o(fin_valid), .fin_pkt_ref_o(fin_pkt), .fin_queue_id_o(fin_qid),
        .sig_rd_req_o(rd_req), .sig_rd_addr_o(rd_addr),
        .sig_rd_rsp_valid_i(rd_rsp_valid), .sig_rd_rsp_data_i(rd_rsp_data),
        .sig_wr_req_o(wr_req), .sig_wr_addr_o(wr_addr), .sig_wr_data_o(wr_data),
        .sig_wr_ack_i(wr_ack), .err_o(err)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 0;

    // Writeback vectors on one kernel: {code[1:0], resp, done, err}
    localparam int NVEC = 9;
    localparam logic [4:0] WB_VEC [NVEC] = '{
        {2'b01, 1'b1, 1'b0, 1'b0},
        {2'b01, 1'b1, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b1, 1'b0},
        {2'b11, 1'b0, 1'b0, 1'b1},
        {2'b10, 1'b0, 1'b0, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b0, 1'b1},
        {2'b11, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [KW-1:0] k, input logic [WW-1:0] t,
                            input logic [PW-1:0] p, input logic [QW-1:0] q,
                            input logic [AW-1:0] h);
        alloc_valid = 1; alloc_kid = k; alloc_total = t;
        alloc_pkt = p; alloc_qid = q; alloc_handle = h;
        tick();
        alloc_valid = 0;
    endtask

    task automatic do_inv(input logic [KW-1:0] k, input logic [1:0] c);
        inv_valid = 1; inv_kid = k; inv_delta = c;
        tick();
        inv_valid = 0;
    endtask

    task automatic do_wg(input logic [KW-1:0] k);
        wg_valid = 1; wg_kid = k;
        tick();
        wg_valid = 0;
    endtask

    task automatic do_ack();
        wake_ack = 1;
        tick();
        wake_ack = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        eq("R12 wake_req", wake_req, 0);
        eq("R12 err", err, 0);
        eq("R12 rd_req", rd_req, 0);
        eq("R12 wr_req", wr_req, 0);
        eq("R12 fin_valid", fin_valid, 0);
        rst_n = 1;
        tick();
        lastq_kid = 0; #1;
        eq("R12 no record in use", lastq_is_last, 0);

        // R1: allocate kernel 1
        do_alloc(2'd1, 4'd1, 16'h1111, 4'd1, 16'h0);
        eq("R1 alloc accepted", err, 0);

        // R4 R2 R11: writeback vector table
        for (int i = 0; i < NVEC; i++) begin
            wb_valid = 1; wb_kid = 2'd1; wb_delta = WB_VEC[i][4:3];
            tick();
            wb_valid = 0;
            eq($sformatf("R4 resp vec%0d", i), wb_resp, WB_VEC[i][2]);
            if (WB_VEC[i][2]) eq($sformatf("R4 done vec%0d", i), wb_done, WB_VEC[i][1]);
            eq($sformatf("R2 R11 err vec%0d", i), err, WB_VEC[i][0]);
        end

        // R11: invalidate counter ceiling
        for (int i = 0; i < 7; i++) begin
            do_inv(2'd1, 2'b01);
            eq("R11 inc below max", err, 0);
        end
        do_inv(2'd1, 2'b01);
        eq("R11 inc at max", err, 1);
        // R2: illegal code leaves count unchanged
        do_inv(2'd1, 2'b10);
        eq("R2 bad inv code", err, 1);
        eq("R2 no wake on bad code", wake_req, 0);
        for (int i = 0; i < 6; i++) begin
            do_inv(2'd1, 2'b11);
            eq("R3 no early drain", inv_drained, 0);
        end
        do_inv(2'd1, 2'b11);
        eq("R3 drained", inv_drained, 1);
        eq("R3 drained kid", inv_drained_kid, 1);
        eq("R5 wake after drain", wake_req, 1);
        do_inv(2'd1, 2'b11);
        eq("R11 dec at zero", err, 1);
        eq("R11 no drain at zero", inv_drained, 0);
        do_ack();
        eq("R5 ack clears", wake_req, 0);

        // R1 R10: rejected allocations and unallocated lookups
        do_alloc(2'd1, 4'd2, 16'h9999, 4'd9, 16'h0);
        eq("R1 realloc live id", err, 1);
        do_alloc(2'd2, 4'd0, 16'h9999, 4'd9, 16'h0);
        eq("R1 zero total", err, 1);
        do_wg(2'd2);
        eq("R10 wg unallocated err", err, 1);
        eq("R10 wg unallocated no wake", wake_req, 0);
        eq("R10 wg unallocated no fin", fin_valid, 0);
        do_inv(2'd2, 2'b01);
        eq("R10 inv unallocated", err, 1);
        lastq_kid = 2'd2; #1;
        eq("R6 query unallocated", lastq_is_last, 0);

        // R6 R7 R5 R8: kernel 0 without signal address
        do_alloc(2'd0, 4'd3, 16'h1234, 4'd5, 16'h0);
        eq("R1 alloc kernel0", err, 0);
        lastq_kid = 2'd0; #1;
        eq("R6 0 of 3", lastq_is_last, 0);
        do_wg(2'd0);
        eq("R5 wake after wg", wake_req, 1);
        eq("R7 no fin 1 of 3", fin_valid, 0);
        eq("R6 1 of 3", lastq_is_last, 0);
        wake_ack = 1;
        do_wg(2'd0);
        wake_ack = 0;
        eq("R5 ack with trigger keeps wake", wake_req, 1);
        eq("R6 2 of 3", lastq_is_last, 1);
        do_ack();
        eq("R5 ack clears again", wake_req, 0);
        do_wg(2'd0);
        eq("R7 fin pulse", fin_valid, 1);
        eq("R7 fin pkt", fin_pkt, 16'h1234);
        eq("R7 fin qid", fin_qid, 4'd5);
        eq("R6 after finish", lastq_is_last, 0);
        tick();
        eq("R7 fin one cycle", fin_valid, 0);
        repeat (2) begin
            tick();
            eq("R8 no read without address", rd_req, 0);
        end
        do_wg(2'd0);
        eq("R10 wg after release", err, 1);
        do_ack();

        // R8 R9: two kernels with signal addresses
        do_alloc(2'd2, 4'd1, 16'h2222, 4'd2, 16'h0040);
        do_alloc(2'd3, 4'd1, 16'h3333, 4'd3, 16'h0080);
        eq("R1 alloc kernel3", err, 0);
        do_wg(2'd3);
        eq("R7 fin kernel3", fin_valid, 1);
        eq("R7 fin pkt kernel3", fin_pkt, 16'h3333);
        eq("R8 read not yet", rd_req, 0);
        do_wg(2'd2);
        eq("R7 fin kernel2", fin_valid, 1);
        eq("R7 fin qid kernel2", fin_qid, 4'd2);
        eq("R8 read raised", rd_req, 1);
        eq("R8 read addr kernel3", rd_addr, 16'h0080);
        repeat (2) tick();
        eq("R8 read held", rd_req, 1);
        eq("R8 read addr held", rd_addr, 16'h0080);
        rd_rsp_valid = 1; rd_rsp_data = 16'd5;
        tick();
        rd_rsp_valid = 0;
        eq("R8 write raised", wr_req, 1);
        eq("R8 write addr", wr_addr, 16'h0080);
        eq("R8 write data", wr_data, 16'd4);
        eq("R9 no read during write", rd_req, 0);
        repeat (3) begin
            tick();
            eq("R9 second kernel waits", rd_req, 0);
            eq("R8 write held", wr_req, 1);
        end
        wr_ack = 1;
        tick();
        wr_ack = 0;
        eq("R8 write dropped after ack", wr_req, 0);
        tick();
        eq("R9 second read raised", rd_req, 1);
        eq("R9 second read addr", rd_addr, 16'h0040);
        rd_rsp_valid = 1; rd_rsp_data = 16'd1;
        tick();
        rd_rsp_valid = 0;
        eq("R8 second write data", wr_data, 16'd0);
        eq("R8 second write addr", wr_addr, 16'h0040);
        wr_ack = 1;
        tick();
        wr_ack = 0;
        tick();
        eq("R8 engine idle", rd_req | wr_req, 0);
        do_wg(2'd3);
        eq("R8 kernel3 released", err, 1);
        do_alloc(2'd3, 4'd2, 16'h4444, 4'd4, 16'h0);
        eq("R1 realloc freed id", err, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule